// File: doc/BRIEF.md
# DMA Stream Error Manager

This block watches one DMA stream and records the faults that can arise while the stream moves data. It takes the stream's configuration as inputs: enable, direction, direct or FIFO mode, memory increment, double-buffer target, FIFO threshold, memory burst length and memory data size. It also sees the bus error responses, the peripheral request and memory-grant handshakes, the FIFO fill status and software writes to the two memory address registers. From these it keeps three sticky flags: transfer error, FIFO error and direct-mode error. Software clears each flag by writing a one.

The block owns the stream enable bit. Software writes that bit, and the block refuses an enable whose FIFO threshold cannot hold a whole number of memory bursts. That is the only fault treated as fatal. Overrun and underrun leave the stream running. While either one is present, the peripheral acknowledge is held back, so no item is lost. A single interrupt line combines the three flags with their enables.

Top module: `dma_err_unit`

## Requirements
- R1: A bus error on a read or write access (`bus_rd_err_i` or `bus_wr_err_i` high for one cycle) sets the transfer-error flag, `flags_o[0]`, on the next clock edge.
- R2: A software write to a memory address register sets `flags_o[0]` when the stream is enabled, double-buffer mode is on, and that register is the current target. A write to `mar0` counts when `cfg_ct_i` is 0, and a write to `mar1` counts when it is 1. A write to the register that is not the target leaves the flag clear.
- R3: Direction codes are 0 for peripheral-to-memory, 1 for memory-to-peripheral and 2 for memory-to-memory. The FIFO-error flag, `flags_o[1]`, is set on the next edge in two cases while the stream is enabled. Overrun is a peripheral request with `fifo_full_i` high in direction 0. Underrun is a peripheral request with `fifo_empty_i` high in direction 1. Direction 2 never raises this flag.
- R4: A software write of enable = 1 while the stream is off is refused when the configuration is incompatible. The enable stays 0, and `flags_o[1]` is set on the next edge. The incompatibility rule uses these codes:
  - Threshold code n gives a threshold of (n+1)/4 of FIFO_BYTES bytes (16 by default).
  - Burst codes 0, 1, 2 and 3 mean 1, 4, 8 and 16 beats.
  - Size codes 0, 1 and 2 mean 1, 2 and 4 bytes. Size code 3 is always incompatible.
  - The configuration is incompatible when the threshold in bytes is not a whole multiple of beats times size.
- R5: Overrun, underrun and direct-mode errors never clear `stream_en_o`. Only a software write changes it, apart from the refusal in R4.
- R6: The direct-mode-error flag, `flags_o[2]`, is set only in direction 0 with `cfg_direct_i` = 1 and `cfg_minc_i` = 0. It is set when a new peripheral request arrives while the previously acknowledged item still waits for `mem_gnt_i`. A new request is one whose request was low, or was acknowledged, in the cycle before.
- R7: `pack_o` acknowledges a peripheral request of an enabled stream in the same cycle. It stays low while an overrun or underrun condition is present, and rises in the cycle that condition goes away.
- R8: `irq_o` is high exactly when some flag in `flags_o` is set and its bit in `ie_i` is set.
- R9: Each flag stays set until a one is written to its bit of `clr_i`. When a set event and a clear write hit the same flag in the same cycle, the flag stays set.
- R10: After reset, all flags are clear, `stream_en_o` is 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr_i | input | 1 | Software write strobe for the enable bit |
| en_wdata_i | input | 1 | Value written to the enable bit |
| cfg_dir_i | input | 2 | Direction: 0 peripheral-to-memory, 1 memory-to-peripheral, 2 memory-to-memory |
| cfg_direct_i | input | 1 | Direct mode (1) or FIFO mode (0) |
| cfg_minc_i | input | 1 | Memory address increment on |
| cfg_dbm_i | input | 1 | Double-buffer mode on |
| cfg_ct_i | input | 1 | Current target memory (0 or 1) |
| cfg_fth_i | input | 2 | FIFO threshold code |
| cfg_mburst_i | input | 2 | Memory burst code |
| cfg_msize_i | input | 2 | Memory data size code |
| bus_rd_err_i | input | 1 | Bus error on a read access |
| bus_wr_err_i | input | 1 | Bus error on a write access |
| mar0_wr_i | input | 1 | Software write to memory address register 0 |
| mar1_wr_i | input | 1 | Software write to memory address register 1 |
| preq_i | input | 1 | Peripheral request level |
| mem_gnt_i | input | 1 | Memory bus grant for the pending item |
| fifo_full_i | input | 1 | FIFO (or direct holding stage) full |
| fifo_empty_i | input | 1 | FIFO (or direct holding stage) empty |
| clr_i | input | 3 | Write-one-to-clear strobes: bit 0 transfer, bit 1 FIFO, bit 2 direct-mode |
| ie_i | input | 3 | Interrupt enables, same bit order as the flags |
| flags_o | output | 3 | Sticky error flags: bit 0 transfer, bit 1 FIFO, bit 2 direct-mode |
| stream_en_o | output | 1 | Stream enable bit |
| pack_o | output | 1 | Peripheral acknowledge |
| irq_o | output | 1 | Error interrupt |

## Verification
The assertions assume two things about the inputs. The peripheral holds its request until it is acknowledged, and then drops it. Configuration inputs change only while the stream is off, or between checks. The stimulus keeps to this. It changes configuration only while nothing is pending. It raises and drops `preq_i` one cycle at a time around each acknowledge. It drives every input just after the falling clock edge, so each clocked property sees stable values. The enable-refusal property recomputes incompatibility with plain division, and the bench keeps the size code inside the defined range.

// File: rtl/dma_err_pkg.sv
package dma_err_pkg;
  typedef enum logic [1:0] {
    DIR_P2M = 2'd0,
    DIR_M2P = 2'd1,
    DIR_M2M = 2'd2,
    DIR_RSV = 2'd3
  } dir_e;

  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FLG_TE    = 0;
  localparam int unsigned FLG_FE    = 1;
  localparam int unsigned FLG_DME   = 2;
  localparam int unsigned MAX_BEATS = 16;
endpackage

// File: rtl/dma_err_cfgchk.sv
module dma_err_cfgchk
  import dma_err_pkg::*;
#(
  parameter int unsigned FIFO_BYTES = 16
) (
  input  logic [1:0] fth_i,
  input  logic [1:0] mburst_i,
  input  logic [1:0] msize_i,
  output logic       bad_o
);
  localparam int unsigned UW = $clog2(MAX_BEATS * 4) + 1;
  localparam int unsigned QUARTER = FIFO_BYTES / 4;

  logic [UW-1:0] fth_bytes;
  logic [UW-1:0] beats;
  logic [UW-1:0] unit;

  always_comb begin
    fth_bytes = UW'((32'(fth_i) + 32'd1) * QUARTER);
    case (mburst_i)
      2'd0:    beats = UW'(1);
      2'd1:    beats = UW'(4);
      2'd2:    beats = UW'(8);
      default: beats = UW'(MAX_BEATS);
    endcase
    unit  = (msize_i == 2'd3) ? beats : (beats << msize_i);
    bad_o = (msize_i == 2'd3) || (|(fth_bytes & (unit - UW'(1))));
  end
endmodule

// File: rtl/dma_err_enable.sv
module dma_err_enable
  import dma_err_pkg::*;
#(
  parameter int unsigned FIFO_BYTES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_wr_i,
  input  logic       en_wdata_i,
  input  logic [1:0] fth_i,
  input  logic [1:0] mburst_i,
  input  logic [1:0] msize_i,
  output logic       en_o,
  output logic       cfg_fault_o
);
  logic en_q, en_n;
  logic cfg_bad;
  logic rise;

  dma_err_cfgchk #(.FIFO_BYTES(FIFO_BYTES)) u_cfgchk (
    .fth_i    (fth_i),
    .mburst_i (mburst_i),
    .msize_i  (msize_i),
    .bad_o    (cfg_bad)
  );

  always_comb begin
    rise        = en_wr_i && en_wdata_i && !en_q;
    cfg_fault_o = rise && cfg_bad;
    en_n        = en_q;
    if (en_wr_i) begin
      en_n = en_wdata_i && !cfg_fault_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_n;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/dma_err_detect.sv
module dma_err_detect
  import dma_err_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic [1:0]           dir_i,
  input  logic                 direct_i,
  input  logic                 minc_i,
  input  logic                 dbm_i,
  input  logic                 ct_i,
  input  logic                 bus_rd_err_i,
  input  logic                 bus_wr_err_i,
  input  logic                 mar0_wr_i,
  input  logic                 mar1_wr_i,
  input  logic                 preq_i,
  input  logic                 mem_gnt_i,
  input  logic                 fifo_full_i,
  input  logic                 fifo_empty_i,
  output logic                 pack_o,
  output logic                 te_evt_o,
  output logic                 fe_evt_o,
  output logic                 dme_evt_o
);
  dir_e dir;
  logic ovr, unr, tgt_wr;
  logic direct_chk, new_req;
  logic preq_q, preq_n;
  logic ack_q, ack_n;
  logic busy_q, busy_n;

  always_comb begin
    dir        = dir_e'(dir_i);
    ovr        = en_i && (dir == DIR_P2M) && preq_i && fifo_full_i;
    unr        = en_i && (dir == DIR_M2P) && preq_i && fifo_empty_i;
    pack_o     = en_i && preq_i && !ovr && !unr;
    tgt_wr     = (mar0_wr_i && !ct_i) || (mar1_wr_i && ct_i);
    te_evt_o   = bus_rd_err_i || bus_wr_err_i || (en_i && dbm_i && tgt_wr);
    fe_evt_o   = ovr || unr;
    direct_chk = en_i && (dir == DIR_P2M) && direct_i && !minc_i;
    new_req    = preq_i && (!preq_q || ack_q);
    dme_evt_o  = direct_chk && new_req && busy_q && !mem_gnt_i;

    preq_n = preq_i;
    ack_n  = pack_o;
    if (!direct_chk) begin
      busy_n = 1'b0;
    end else if (pack_o) begin
      busy_n = 1'b1;
    end else if (mem_gnt_i) begin
      busy_n = 1'b0;
    end else begin
      busy_n = busy_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preq_q <= 1'b0;
      ack_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      preq_q <= preq_n;
      ack_q  <= ack_n;
      busy_q <= busy_n;
    end
  end
endmodule

// File: rtl/dma_err_flags.sv
module dma_err_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ie_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  logic [N-1:0] flag_q;
  logic [N-1:0] flag_n;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      if (set_i[i]) begin
        flag_n[i] = 1'b1;
      end else if (clr_i[i]) begin
        flag_n[i] = 1'b0;
      end else begin
        flag_n[i] = flag_q[i];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
      end else begin
        flag_q[i] <= flag_n[i];
      end
    end
  end

  assign flags_o = flag_q;
  assign irq_o   = |(flag_q & ie_i);
endmodule

// File: rtl/dma_err_unit.sv
module dma_err_unit
  import dma_err_pkg::*;
#(
  parameter int unsigned FIFO_BYTES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_wr_i,
  input  logic       en_wdata_i,
  input  logic [1:0] cfg_dir_i,
  input  logic       cfg_direct_i,
  input  logic       cfg_minc_i,
  input  logic       cfg_dbm_i,
  input  logic       cfg_ct_i,
  input  logic [1:0] cfg_fth_i,
  input  logic [1:0] cfg_mburst_i,
  input  logic [1:0] cfg_msize_i,
  input  logic       bus_rd_err_i,
  input  logic       bus_wr_err_i,
  input  logic       mar0_wr_i,
  input  logic       mar1_wr_i,
  input  logic       preq_i,
  input  logic       mem_gnt_i,
  input  logic       fifo_full_i,
  input  logic       fifo_empty_i,
  input  logic [2:0] clr_i,
  input  logic [2:0] ie_i,
  output logic [2:0] flags_o,
  output logic       stream_en_o,
  output logic       pack_o,
  output logic       irq_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       cfg_fault;
  logic       te_evt, fe_evt, dme_evt;
  logic [NUM_FLAGS-1:0] set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  dma_err_enable #(.FIFO_BYTES(FIFO_BYTES)) u_enable (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .en_wr_i     (en_wr_i),
    .en_wdata_i  (en_wdata_i),
    .fth_i       (cfg_fth_i),
    .mburst_i    (cfg_mburst_i),
    .msize_i     (cfg_msize_i),
    .en_o        (stream_en_o),
    .cfg_fault_o (cfg_fault)
  );

  dma_err_detect u_detect (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .en_i         (stream_en_o),
    .dir_i        (cfg_dir_i),
    .direct_i     (cfg_direct_i),
    .minc_i       (cfg_minc_i),
    .dbm_i        (cfg_dbm_i),
    .ct_i         (cfg_ct_i),
    .bus_rd_err_i (bus_rd_err_i),
    .bus_wr_err_i (bus_wr_err_i),
    .mar0_wr_i    (mar0_wr_i),
    .mar1_wr_i    (mar1_wr_i),
    .preq_i       (preq_i),
    .mem_gnt_i    (mem_gnt_i),
    .fifo_full_i  (fifo_full_i),
    .fifo_empty_i (fifo_empty_i),
    .pack_o       (pack_o),
    .te_evt_o     (te_evt),
    .fe_evt_o     (fe_evt),
    .dme_evt_o    (dme_evt)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[FLG_TE]  = te_evt;
    set_vec[FLG_FE]  = fe_evt || cfg_fault;
    set_vec[FLG_DME] = dme_evt;
  end

  dma_err_flags #(.N(NUM_FLAGS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_i   (set_vec),
    .clr_i   (clr_i),
    .ie_i    (ie_i),
    .flags_o (flags_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/dma_err_unit_chk.sv
module dma_err_unit_chk #(
  parameter int unsigned FIFO_BYTES = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       en_wr_i,
  input logic       en_wdata_i,
  input logic [1:0] cfg_dir_i,
  input logic [1:0] cfg_fth_i,
  input logic [1:0] cfg_mburst_i,
  input logic [1:0] cfg_msize_i,
  input logic       bus_rd_err_i,
  input logic       bus_wr_err_i,
  input logic       preq_i,
  input logic       fifo_full_i,
  input logic       fifo_empty_i,
  input logic [2:0] clr_i,
  input logic [2:0] flags_o,
  input logic       stream_en_o,
  input logic       pack_o,
  input logic       irq_o
);
  int unsigned thr_b, burst_b;
  logic        cfg_incompat;

  always_comb begin
    thr_b = (32'(cfg_fth_i) + 1) * (FIFO_BYTES / 4);
    case (cfg_mburst_i)
      2'd0:    burst_b = 1;
      2'd1:    burst_b = 4;
      2'd2:    burst_b = 8;
      default: burst_b = 16;
    endcase
    if (cfg_msize_i == 2'd3) begin
      cfg_incompat = 1'b1;
    end else begin
      burst_b      = burst_b * (32'd1 << cfg_msize_i);
      cfg_incompat = (thr_b % burst_b) != 0;
    end
  end

  assert_bus_err_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_err_i || bus_wr_err_i) |=> flags_o[0]);

  assert_refuse_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr_i && en_wdata_i && !stream_en_o && cfg_incompat) |=> (!stream_en_o && flags_o[1]));

  assert_keep_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stream_en_o && !en_wr_i) |=> stream_en_o);

  assert_hold_ack_ovr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dir_i == 2'd0 && fifo_full_i) |-> !pack_o);

  assert_hold_ack_unr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dir_i == 2'd1 && fifo_empty_i) |-> !pack_o);

  assert_ack_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pack_o |-> (preq_i && stream_en_o));

  assert_quiet_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o == 3'b000) |-> !irq_o);

  assert_sticky_te_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[0] && !clr_i[0]) |=> flags_o[0]);

  assert_sticky_fe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[1] && !clr_i[1]) |=> flags_o[1]);

  assert_sticky_dme_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[2] && !clr_i[2]) |=> flags_o[2]);
endmodule

bind dma_err_unit dma_err_unit_chk #(.FIFO_BYTES(FIFO_BYTES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .en_wr_i      (en_wr_i),
  .en_wdata_i   (en_wdata_i),
  .cfg_dir_i    (cfg_dir_i),
  .cfg_fth_i    (cfg_fth_i),
  .cfg_mburst_i (cfg_mburst_i),
  .cfg_msize_i  (cfg_msize_i),
  .bus_rd_err_i (bus_rd_err_i),
  .bus_wr_err_i (bus_wr_err_i),
  .preq_i       (preq_i),
  .fifo_full_i  (fifo_full_i),
  .fifo_empty_i (fifo_empty_i),
  .clr_i        (clr_i),
  .flags_o      (flags_o),
  .stream_en_o  (stream_en_o),
  .pack_o       (pack_o),
  .irq_o        (irq_o)
);

// File: tb/dma_err_unit_tb.sv
`timescale 1ns/1ps
module dma_err_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en_wr_i, en_wdata_i;
  logic [1:0] cfg_dir_i;
  logic       cfg_direct_i, cfg_minc_i, cfg_dbm_i, cfg_ct_i;
  logic [1:0] cfg_fth_i, cfg_mburst_i, cfg_msize_i;
  logic       bus_rd_err_i, bus_wr_err_i, mar0_wr_i, mar1_wr_i;
  logic       preq_i, mem_gnt_i, fifo_full_i, fifo_empty_i;
  logic [2:0] clr_i, ie_i;
  logic [2:0] flags_o;
  logic       stream_en_o, pack_o, irq_o;

  int checks   = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  dma_err_unit u_dut (
    .clk(clk), .rst_n(rst_n), .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
    .cfg_dir_i(cfg_dir_i), .cfg_direct_i(cfg_direct_i), .cfg_minc_i(cfg_minc_i),
    .cfg_dbm_i(cfg_dbm_i), .cfg_ct_i(cfg_ct_i), .cfg_fth_i(cfg_fth_i),
    .cfg_mburst_i(cfg_mburst_i), .cfg_msize_i(cfg_msize_i),
    .bus_rd_err_i(bus_rd_err_i), .bus_wr_err_i(bus_wr_err_i),
    .mar0_wr_i(mar0_wr_i), .mar1_wr_i(mar1_wr_i), .preq_i(preq_i),
    .mem_gnt_i(mem_gnt_i), .fifo_full_i(fifo_full_i), .fifo_empty_i(fifo_empty_i),
    .clr_i(clr_i), .ie_i(ie_i), .flags_o(flags_o), .stream_en_o(stream_en_o),
    .pack_o(pack_o), .irq_o(irq_o)
  );

  // entry: [6:5] threshold code, [4:3] burst code, [2:1] size code, [0] refused
  localparam int NV = 10;
  localparam logic [6:0] VEC [NV] = '{
    {2'd0, 2'd0, 2'd0, 1'b0},
    {2'd0, 2'd1, 2'd0, 1'b0},
    {2'd0, 2'd1, 2'd1, 1'b1},
    {2'd1, 2'd2, 2'd0, 1'b0},
    {2'd2, 2'd2, 2'd0, 1'b1},
    {2'd2, 2'd1, 2'd0, 1'b0},
    {2'd3, 2'd3, 2'd0, 1'b0},
    {2'd3, 2'd1, 2'd2, 1'b0},
    {2'd1, 2'd1, 2'd2, 1'b1},
    {2'd3, 2'd3, 2'd1, 1'b1}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    clr_i = 3'b111;
    tick();
    clr_i = 3'b000;
  endtask

  task automatic write_en(input logic v);
    en_wr_i = 1'b1;
    en_wdata_i = v;
    tick();
    en_wr_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    {en_wr_i, en_wdata_i, cfg_direct_i, cfg_minc_i, cfg_dbm_i, cfg_ct_i} = '0;
    {bus_rd_err_i, bus_wr_err_i, mar0_wr_i, mar1_wr_i} = '0;
    {preq_i, mem_gnt_i, fifo_full_i, fifo_empty_i} = '0;
    cfg_dir_i = 2'd0; cfg_fth_i = 2'd3; cfg_mburst_i = 2'd0; cfg_msize_i = 2'd0;
    clr_i = 3'b000; ie_i = 3'b000;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    chk("R10 flags", 8'(flags_o), 8'h0);
    chk("R10 enable", 8'(stream_en_o), 8'h0);
    chk("R10 irq", 8'(irq_o), 8'h0);

    // table of threshold/burst/size combinations
    for (int i = 0; i < NV; i++) begin
      write_en(1'b0);
      clear_all();
      cfg_fth_i = VEC[i][6:5]; cfg_mburst_i = VEC[i][4:3]; cfg_msize_i = VEC[i][2:1];
      write_en(1'b1);
      chk("R4 enable result", 8'(stream_en_o), 8'(!VEC[i][0]));
      chk("R4 fifo flag", 8'(flags_o[1]), 8'(VEC[i][0]));
    end

    write_en(1'b0);
    cfg_fth_i = 2'd3; cfg_mburst_i = 2'd0; cfg_msize_i = 2'd0;
    clear_all();
    write_en(1'b1);
    chk("R4 compatible enable", 8'(stream_en_o), 8'h1);

    bus_rd_err_i = 1'b1; tick(); bus_rd_err_i = 1'b0;
    chk("R1 read error", 8'(flags_o), 8'h1);
    chk("R8 masked irq", 8'(irq_o), 8'h0);
    ie_i = 3'b001; #1;
    chk("R8 enabled irq", 8'(irq_o), 8'h1);
    clr_i = 3'b001; bus_wr_err_i = 1'b1; tick(); clr_i = 3'b000; bus_wr_err_i = 1'b0;
    chk("R9 set wins over clear", 8'(flags_o[0]), 8'h1);
    clr_i = 3'b001; tick(); clr_i = 3'b000;
    chk("R9 clear", 8'(flags_o[0]), 8'h0);
    ie_i = 3'b000;

    cfg_dbm_i = 1'b1; cfg_ct_i = 1'b1;
    mar0_wr_i = 1'b1; tick(); mar0_wr_i = 1'b0;
    chk("R2 non-target write", 8'(flags_o[0]), 8'h0);
    mar1_wr_i = 1'b1; tick(); mar1_wr_i = 1'b0;
    chk("R2 target write", 8'(flags_o[0]), 8'h1);
    cfg_dbm_i = 1'b0;
    clear_all();

    cfg_dir_i = 2'd0; fifo_full_i = 1'b1; preq_i = 1'b1; #1;
    chk("R7 ack held on overrun", 8'(pack_o), 8'h0);
    tick();
    chk("R3 overrun flag", 8'(flags_o[1]), 8'h1);
    chk("R5 enable kept after overrun", 8'(stream_en_o), 8'h1);
    fifo_full_i = 1'b0; #1;
    chk("R7 ack released", 8'(pack_o), 8'h1);
    preq_i = 1'b0;
    clear_all();

    cfg_dir_i = 2'd1; fifo_empty_i = 1'b1; preq_i = 1'b1; #1;
    chk("R7 ack held on underrun", 8'(pack_o), 8'h0);
    tick();
    chk("R3 underrun flag", 8'(flags_o[1]), 8'h1);
    fifo_empty_i = 1'b0; preq_i = 1'b0;
    clear_all();

    cfg_dir_i = 2'd2; fifo_full_i = 1'b1; preq_i = 1'b1; tick();
    chk("R3 no overrun mem-to-mem", 8'(flags_o[1]), 8'h0);
    fifo_full_i = 1'b0; preq_i = 1'b0; tick();

    cfg_dir_i = 2'd0; cfg_direct_i = 1'b1; cfg_minc_i = 1'b0;
    preq_i = 1'b1; tick(); preq_i = 1'b0; tick();
    chk("R6 single request", 8'(flags_o[2]), 8'h0);
    preq_i = 1'b1; tick(); preq_i = 1'b0;
    chk("R6 second request without grant", 8'(flags_o[2]), 8'h1);
    chk("R5 enable kept after direct error", 8'(stream_en_o), 8'h1);
    ie_i = 3'b100; #1;
    chk("R8 direct irq", 8'(irq_o), 8'h1);
    ie_i = 3'b000;
    mem_gnt_i = 1'b1; tick(); mem_gnt_i = 1'b0;
    clear_all();

    cfg_minc_i = 1'b1;
    preq_i = 1'b1; tick(); preq_i = 1'b0; tick();
    preq_i = 1'b1; tick(); preq_i = 1'b0; tick();
    chk("R6 increment on blocks flag", 8'(flags_o[2]), 8'h0);

    cfg_minc_i = 1'b0;
    preq_i = 1'b1; tick(); preq_i = 1'b0; mem_gnt_i = 1'b1; tick(); mem_gnt_i = 1'b0;
    preq_i = 1'b1; tick(); preq_i = 1'b0; tick();
    chk("R6 granted in time", 8'(flags_o[2]), 8'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule